// File: doc/BRIEF.md
# Charger High-Current Enable Controller

This block decides when a phone's charger is allowed to draw high current. Analog comparators outside the block reduce the line conditions to single bits: the ID pin above the factory-mode level, the supply above its enable level, and the bus voltage above session-valid. The block also receives the raw DP and DM line levels. It synchronises DP and DM and measures how long both stay high (single-ended one, SE1) against a programmable millisecond count. It then merges the qualifying conditions into one registered enable output.

Software can force the output to a chosen level through an override pair. However, a supply below the enable level always holds the output low. A second output requests detector bias. It is always requested in normal operation. During software power-down it is requested only while the bus voltage is session-valid, so that detection can wake the system.

The millisecond reference is a one-cycle `ms_tick` pulse, produced elsewhere from the system clock. Reset is asynchronous, active low, and leaves the block through a two-stage release synchroniser.

Top module: `chg_detect_ctl`

## Requirements
- R1: While reset is applied, `chg_hi_out` and `bias_req` are both 0.
- R2: With `sup_ok`=1, `sess_ok`=1, `id_fm_hi`=1 and `ovr_en`=0, `chg_hi_out` is 1 after the next rising clock edge.
- R3: With `sup_ok`=1, `sess_ok`=1 and `ovr_en`=0, holding `dp_in`=`dm_in`=1 sets `chg_hi_out` to 1 only after `se1_set` `ms_tick` pulses have been counted during the synchronised SE1 condition. The output rises on the second edge after the pulse that reaches the count.
- R4: With `se1_set`=0, SE1 qualifies on the first synchronised sample. `chg_hi_out` rises on the third rising edge after DP and DM are both driven high (two synchroniser stages plus the output register).
- R5: Any break in SE1 that reaches the synchronised signal clears the millisecond count, so timing restarts from zero when SE1 returns.
- R6: When `sup_ok`=0, `chg_hi_out` is 0 after the next edge, whatever the other inputs are, including an active override.
- R7: When `sess_ok`=0 and the override is inactive, neither the ID condition nor the SE1 condition can drive `chg_hi_out` high.
- R8: When `ovr_en`=1 and `sup_ok`=1, `chg_hi_out` follows `ovr_state` one edge later, and the detection results are ignored.
- R9: Without an override, `chg_hi_out` falls on the first edge at which the qualifying condition is no longer seen. For SE1, this is the third edge after a line goes low.
- R10: `bias_req` is registered and equals 1 when `pwr_dn`=0. When `pwr_dn`=1, it equals `sess_ok` from the previous cycle.
- R11: The millisecond count saturates at 15, so a setting of 15 stays qualified for as long as SE1 is held, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_fm_hi | input | 1 | ID pin above factory-mode threshold |
| sup_ok | input | 1 | Supply above enable threshold |
| sess_ok | input | 1 | Bus voltage above session-valid |
| dp_in | input | 1 | Raw DP line level |
| dm_in | input | 1 | Raw DM line level |
| se1_set | input | 4 | Required SE1 duration in ms (0 to 15) |
| ovr_en | input | 1 | Software override enable |
| ovr_state | input | 1 | Output level used while override is enabled |
| pwr_dn | input | 1 | Software power-down |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| chg_hi_out | output | 1 | High-current enable output |
| bias_req | output | 1 | Detector bias request |

## Verification
A vector table sweeps the ID path through every gating combination. These vectors separate supply gating from session gating, and show that the override wins over detection but loses to a low supply. Directed SE1 runs use settings 0, 3 and 15. They show the synchroniser latency, whether the count is exact or off by one, and whether the counter saturates. A one-cycle line break partway through timing shows whether the count restarts or merely pauses. Toggling power-down against session validity exercises the bias request.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int unsigned SET_W       = 4;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic id_fm_hi;
    logic sup_ok;
    logic sess_ok;
    logic ovr_en;
    logic ovr_state;
  } chg_ctl_t;
endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      always_comb stg_d = d;
    end else begin : g_rest
      always_comb stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/chg_se1_timer.sv
module chg_se1_timer #(
  parameter int unsigned SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             se1,
  input  logic             tick,
  input  logic [SET_W-1:0] set_ms,
  output logic             qual
);
  localparam logic [SET_W-1:0] CNT_MAX = {SET_W{1'b1}};
  localparam logic [SET_W-1:0] CNT_ONE = {{(SET_W-1){1'b0}}, 1'b1};

  logic [SET_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!se1) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (tick && (cnt_q != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual = se1 && (cnt_q >= set_ms);

  // R5
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !se1 |=> (cnt_q == '0));

  // R11
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (se1 && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX) || !$past(se1));
endmodule

// File: rtl/chg_out_ctl.sv
module chg_out_ctl
  import chg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  chg_ctl_t ctl,
  input  logic     se1_qual,
  input  logic     pwr_dn,
  output logic     out_q,
  output logic     bias_q
);
  logic out_d, bias_d, detect;

  always_comb begin
    detect = ctl.sess_ok && (ctl.id_fm_hi || se1_qual);
    if (!ctl.sup_ok)     out_d = 1'b0;
    else if (ctl.ovr_en) out_d = ctl.ovr_state;
    else                 out_d = detect;
    bias_d = !pwr_dn || ctl.sess_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      bias_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      bias_q <= bias_d;
    end
  end

  // R2
  id_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sup_ok && ctl.sess_ok && ctl.id_fm_hi && !ctl.ovr_en) |=> out_q);

  // R6
  sup_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.sup_ok |=> !out_q);

  // R8
  ovr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ovr_en && ctl.sup_ok) |=> (out_q == $past(ctl.ovr_state)));

  // R10
  bias_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !ctl.sess_ok) |=> !bias_q);
endmodule

// File: rtl/chg_detect_ctl.sv
module chg_detect_ctl
  import chg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_fm_hi,
  input  logic             sup_ok,
  input  logic             sess_ok,
  input  logic             dp_in,
  input  logic             dm_in,
  input  logic [SET_W-1:0] se1_set,
  input  logic             ovr_en,
  input  logic             ovr_state,
  input  logic             pwr_dn,
  input  logic             ms_tick,
  output logic             chg_hi_out,
  output logic             bias_req
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] line_s;
  logic       se1_s, se1_qual;
  chg_ctl_t   ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  chg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({dp_in, dm_in}),
    .q     (line_s)
  );
  assign se1_s = line_s[1] && line_s[0];

  chg_se1_timer #(.SET_W(SET_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .se1    (se1_s),
    .tick   (ms_tick),
    .set_ms (se1_set),
    .qual   (se1_qual)
  );

  always_comb begin
    ctl.id_fm_hi  = id_fm_hi;
    ctl.sup_ok    = sup_ok;
    ctl.sess_ok   = sess_ok;
    ctl.ovr_en    = ovr_en;
    ctl.ovr_state = ovr_state;
  end

  chg_out_ctl u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctl      (ctl),
    .se1_qual (se1_qual),
    .pwr_dn   (pwr_dn),
    .out_q    (chg_hi_out),
    .bias_q   (bias_req)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst_int_n)
    !chg_hi_out && !bias_req);
endmodule

// File: tb/tb_chg_detect_ctl.sv
module tb_chg_detect_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_fm_hi, sup_ok, sess_ok, dp_in, dm_in;
  logic [3:0] se1_set;
  logic       ovr_en, ovr_state, pwr_dn, ms_tick;
  logic       chg_hi_out, bias_req;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  chg_detect_ctl dut (
    .clk(clk), .rst_n(rst_n), .id_fm_hi(id_fm_hi), .sup_ok(sup_ok),
    .sess_ok(sess_ok), .dp_in(dp_in), .dm_in(dm_in), .se1_set(se1_set),
    .ovr_en(ovr_en), .ovr_state(ovr_state), .pwr_dn(pwr_dn),
    .ms_tick(ms_tick), .chg_hi_out(chg_hi_out), .bias_req(bias_req)
  );

  // vector: {ovr_en, ovr_state, id_fm_hi, sup_ok, sess_ok, expected}
  localparam int NV = 9;
  localparam logic [5:0] VEC [NV] = '{
    6'b00_011_0,  // R2 baseline: no ID
    6'b00_111_1,  // R2 ID qualifies
    6'b00_110_0,  // R7 session invalid
    6'b00_101_0,  // R6 supply low
    6'b11_010_1,  // R8 override high ignores missing detection
    6'b10_111_0,  // R8 override low ignores ID
    6'b11_001_0,  // R6 supply low beats override
    6'b00_111_1,  // R2 again
    6'b00_011_0   // R9 falls when ID ends
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic tick_pulse();
    ms_tick = 1'b1;
    cyc(1);
    ms_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; id_fm_hi = 0; sup_ok = 0; sess_ok = 0; dp_in = 0; dm_in = 0;
    se1_set = 4'd0; ovr_en = 0; ovr_state = 0; pwr_dn = 0; ms_tick = 0;
    @(negedge clk);
    cyc(3);
    chk("R1 out in reset", chg_hi_out, 1'b0);
    chk("R1 bias in reset", bias_req, 1'b0);
    rst_n = 1'b1;
    cyc(4);

    // R10 bias request
    pwr_dn = 0; sess_ok = 0; cyc(1);
    chk("R10 bias no pwr_dn", bias_req, 1'b1);
    pwr_dn = 1; cyc(1);
    chk("R10 bias pwr_dn no session", bias_req, 1'b0);
    sess_ok = 1; cyc(1);
    chk("R10 bias pwr_dn session", bias_req, 1'b1);
    pwr_dn = 0;

    // vector table for ID path and gating
    for (int v = 0; v < NV; v++) begin
      {ovr_en, ovr_state, id_fm_hi, sup_ok, sess_ok} = VEC[v][5:1];
      cyc(1);
      chk($sformatf("R2/R6/R7/R8/R9 vector %0d", v), chg_hi_out, VEC[v][0]);
    end
    ovr_en = 0; ovr_state = 0; id_fm_hi = 0; sup_ok = 1; sess_ok = 1;
    cyc(2);

    // R4 setting 0
    se1_set = 4'd0; dp_in = 1; dm_in = 1;
    cyc(2);
    chk("R4 not yet after two edges", chg_hi_out, 1'b0);
    cyc(1);
    chk("R4 high on third edge", chg_hi_out, 1'b1);
    dm_in = 0;
    cyc(2);
    chk("R9 still high two edges after break", chg_hi_out, 1'b1);
    cyc(1);
    chk("R9 low on third edge after break", chg_hi_out, 1'b0);

    // R7 SE1 blocked by session
    sess_ok = 0; dm_in = 1;
    cyc(4);
    chk("R7 SE1 blocked without session", chg_hi_out, 1'b0);
    sess_ok = 1; cyc(1);
    chk("R3 SE1 setting 0 with session", chg_hi_out, 1'b1);
    // R6 with SE1 qualified
    sup_ok = 0; cyc(1);
    chk("R6 supply low with SE1", chg_hi_out, 1'b0);
    sup_ok = 1;
    dm_in = 0; cyc(4);

    // R3 setting 3
    se1_set = 4'd3; dm_in = 1;
    cyc(3);
    chk("R3 low before ticks", chg_hi_out, 1'b0);
    tick_pulse(); tick_pulse();
    cyc(1);
    chk("R3 low after two ticks", chg_hi_out, 1'b0);
    tick_pulse();
    chk("R3 low on edge of third tick", chg_hi_out, 1'b0);
    cyc(1);
    chk("R3 high after third tick", chg_hi_out, 1'b1);
    dm_in = 0; cyc(4);

    // R5 restart on break
    dm_in = 1; cyc(3);
    tick_pulse(); tick_pulse();
    dm_in = 0; cyc(1); dm_in = 1;
    cyc(4);
    tick_pulse(); tick_pulse();
    cyc(2);
    chk("R5 count restarted after break", chg_hi_out, 1'b0);
    tick_pulse();
    cyc(1);
    chk("R5 qualifies after full recount", chg_hi_out, 1'b1);
    dm_in = 0; cyc(4);

    // R11 saturation at 15
    se1_set = 4'd15; dm_in = 1; cyc(3);
    for (int k = 0; k < 14; k++) tick_pulse();
    cyc(1);
    chk("R11 low after 14 ticks", chg_hi_out, 1'b0);
    for (int k = 0; k < 6; k++) tick_pulse();
    cyc(1);
    chk("R11 high after 20 ticks", chg_hi_out, 1'b1);
    for (int k = 0; k < 10; k++) tick_pulse();
    chk("R11 still high past saturation", chg_hi_out, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule